// File: doc/BRIEF.md
# Tagged Quadword Load Checker

This unit carries out one quadword load from memory that keeps a hidden pointer tag bit beside every 16 data bytes. An instruction supplies a target register, a base register, a signed byte displacement and a 4-bit pointer-type mask. The unit reads the base register and adds the displacement to form the address. It then asks memory for the 128 data bits and their tag. It writes the two doublewords into an even/odd register pair.

In the same cycle as that register write, the unit also writes one fixed bit of a 16-bit extended exception register, bit 41 of a range numbered 32 to 47. The bit says whether the loaded quadword is a valid tagged pointer of one of the requested kinds. A later select instruction can then use that bit to pick either the pointer's address or zero. A request with a misaligned address or an odd target register is rejected at once, and nothing is written.

Top module: `tagLoadUnit`

## Requirements
- R1: The effective address is the base register value plus the 16-bit displacement, sign-extended to 64 bits. It appears on `memReqAddr`, with `memReqValid` high for exactly one cycle, in the cycle after the request is accepted.
- R2: If the effective address has any of bits [3:0] set, or if the target register number is odd, `alignFault` goes high for one cycle in the cycle after the request. In that case no memory request, no register write and no exception update follows.
- R3: One cycle after the cycle in which `memRspValid` is high, `rfWrEn` pulses with the even target number on `rfWrAddrEven`. Bits [127:64] of the response go to the even register (`rfWrDataHi`) and bits [63:0] go to the odd register (`rfWrDataLo`).
- R4: `excWrEn` pulses in the same cycle as `rfWrEn`. `excWrIdx` is 9, which selects bit 41 of the 32..47 range, and `excWrVal` carries the check result.
- R5: The pointer type is response bits [127:124]. Mask and type use the same encoding: bit 3 system, bit 2 instruction, bit 1 space, bit 0 data. The result is 1 only if the tag is 1, the type has exactly one bit set, and that bit is also set in the mask. A type that is not one-hot always gives 0.
- R6: A mask of 0000 gives a result of 0 for any tag and any type.
- R7: A tag of 0 gives a result of 0 for any type and any mask.
- R8: `issueReady` is low from the cycle after a request is accepted until the unit returns to idle. A request presented while `issueReady` is low is ignored and starts no memory request.
- R9: After reset, `issueReady` is high, and `memReqValid`, `rfWrEn`, `excWrEn` and `alignFault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| issueValid | input | 1 | Load request present |
| issueReady | output | 1 | Unit idle, will accept a request |
| fieldTgt | input | 5 | Target register number (must be even) |
| fieldBase | input | 5 | Base register number |
| fieldDisp | input | 16 | Signed byte displacement |
| fieldMask | input | 4 | Accepted pointer types, ORed |
| rfRdAddr | output | 5 | Register-file read address |
| rfRdData | input | 64 | Register-file read data, same cycle |
| memReqValid | output | 1 | Memory read request strobe |
| memReqAddr | output | 64 | Memory read address |
| memRspValid | input | 1 | Memory response strobe |
| memRspData | input | 128 | Quadword returned |
| memRspTag | input | 1 | Pointer tag returned with the quadword |
| rfWrEn | output | 1 | Paired register write strobe |
| rfWrAddrEven | output | 5 | Even register of the pair |
| rfWrDataHi | output | 64 | Data for the even register |
| rfWrDataLo | output | 64 | Data for the odd register |
| excWrEn | output | 1 | Exception bit update strobe |
| excWrIdx | output | 4 | Bit index within the 16 extended bits |
| excWrVal | output | 1 | New value of the exception bit |
| alignFault | output | 1 | Misaligned address or odd target register |

## Verification
A corrupted state register shows up as an early `issueReady` or as a second `memReqValid` pulse, and it is caught at the next cycle boundary. A latched address, target or mask that is wrong makes `memReqAddr` differ one cycle after the request, or makes the paired write or exception value differ in the commit cycle. That commit comes at most a few cycles after the injected response. Errors in the type decode, such as a missing one-hot test or an ignored tag, change only `excWrVal`. For that reason the stimulus mixes non-one-hot types, untagged data and empty masks with valid pointers.

// File: rtl/tagLoadPkg.sv
package tagLoadPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_REQ    = 2'd1,
    ST_WAIT   = 2'd2,
    ST_COMMIT = 2'd3
  } ldState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchIssue;
    logic raiseFault;
    logic captureRsp;
    logic commit;
  } ldStrobe_t;

endpackage

// File: rtl/tagLoadCtl.sv
module tagLoadCtl
  import tagLoadPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      issueValid,
  input  logic      issueBad,
  input  logic      memRspValid,
  output ldStrobe_t strb,
  output logic      memReqValid,
  output logic      issueReady
);

  ldState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.latchIssue = (state == ST_IDLE) && issueValid && !issueBad;
    strb.raiseFault = (state == ST_IDLE) && issueValid && issueBad;
    strb.captureRsp = (state == ST_WAIT) && memRspValid;
    strb.commit     = (state == ST_COMMIT);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (strb.latchIssue) stateNext = ST_REQ;
      ST_REQ:    stateNext = ST_WAIT;
      ST_WAIT:   if (memRspValid) stateNext = ST_COMMIT;
      ST_COMMIT: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign memReqValid = (state == ST_REQ);
  assign issueReady  = (state == ST_IDLE);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid); // R1
  AST_REQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> $past(strb.latchIssue)); // R1
  AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    strb.raiseFault |=> !memReqValid); // R2
  AST_COMMIT_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> $past(memRspValid)); // R3

endmodule

// File: rtl/tagLoadPath.sv
module tagLoadPath
  import tagLoadPkg::*;
#(
  parameter int XLEN      = 64,
  parameter int REGAW     = 5,
  parameter int DISPW     = 16,
  parameter int MASKW     = 4,
  parameter int EXC_BASE  = 32,
  parameter int EXC_COUNT = 16,
  parameter int EXC_BIT   = 41
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ldStrobe_t                    strb,
  input  logic [REGAW-1:0]             fieldTgt,
  input  logic [DISPW-1:0]             fieldDisp,
  input  logic [MASKW-1:0]             fieldMask,
  input  logic [XLEN-1:0]              baseVal,
  input  logic [2*XLEN-1:0]            memRspData,
  input  logic                         memRspTag,
  output logic                         issueBad,
  output logic [XLEN-1:0]              memReqAddr,
  output logic                         alignFault,
  output logic                         rfWrEn,
  output logic [REGAW-1:0]             rfWrAddrEven,
  output logic [XLEN-1:0]              rfWrDataHi,
  output logic [XLEN-1:0]              rfWrDataLo,
  output logic                         excWrEn,
  output logic [$clog2(EXC_COUNT)-1:0] excWrIdx,
  output logic                         excWrVal
);

  localparam int QW      = 2 * XLEN;
  localparam int OFFW    = $clog2(QW / 8);
  localparam int EXTW    = XLEN - DISPW;
  localparam int EXCIW   = $clog2(EXC_COUNT);
  localparam int EXC_IDX = EXC_BIT - EXC_BASE;

  logic [XLEN-1:0]  eaNext, eaQ;
  logic [REGAW-1:0] tgtQ;
  logic [MASKW-1:0] maskQ, typeQ, laneHit;
  logic [QW-1:0]    dataQ;
  logic             tagQ, faultQ, typeOneHot;

  // Effective address and legality
  assign eaNext   = baseVal + {{EXTW{fieldDisp[DISPW-1]}}, fieldDisp};
  assign issueBad = (|eaNext[OFFW-1:0]) | fieldTgt[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ    <= '0;
      tgtQ   <= '0;
      maskQ  <= '0;
      faultQ <= 1'b0;
    end else begin
      faultQ <= strb.raiseFault;
      if (strb.latchIssue) begin
        eaQ   <= eaNext;
        tgtQ  <= fieldTgt;
        maskQ <= fieldMask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
      tagQ  <= 1'b0;
    end else if (strb.captureRsp) begin
      dataQ <= memRspData;
      tagQ  <= memRspTag;
    end
  end

  // Type check: one lane per pointer kind
  assign typeQ = dataQ[QW-1 -: MASKW];
  for (genvar g = 0; g < MASKW; g++) begin : gLane
    assign laneHit[g] = typeQ[g] & maskQ[g];
  end
  assign typeOneHot = $onehot(typeQ);

  assign memReqAddr   = eaQ;
  assign alignFault   = faultQ;
  assign rfWrEn       = strb.commit;
  assign rfWrAddrEven = tgtQ;
  assign rfWrDataHi   = dataQ[QW-1:XLEN];
  assign rfWrDataLo   = dataQ[XLEN-1:0];
  assign excWrEn      = strb.commit;
  assign excWrIdx     = EXC_IDX[EXCIW-1:0];
  assign excWrVal     = tagQ & typeOneHot & (|laneHit);

  AST_EVEN_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> !rfWrAddrEven[0]); // R3
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchIssue |=> (memReqAddr[OFFW-1:0] == '0)); // R2
  AST_HIT_NEEDS_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (excWrEn && excWrVal) |-> $past(memRspTag)); // R7
  AST_ZERO_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (excWrEn && (maskQ == '0)) |-> !excWrVal); // R6
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !rfWrEn); // R2

endmodule

// File: rtl/tagLoadUnit.sv
module tagLoadUnit
  import tagLoadPkg::*;
#(
  parameter int XLEN      = 64,
  parameter int REGAW     = 5,
  parameter int DISPW     = 16,
  parameter int MASKW     = 4,
  parameter int EXC_BASE  = 32,
  parameter int EXC_COUNT = 16,
  parameter int EXC_BIT   = 41
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         issueValid,
  output logic                         issueReady,
  input  logic [REGAW-1:0]             fieldTgt,
  input  logic [REGAW-1:0]             fieldBase,
  input  logic [DISPW-1:0]             fieldDisp,
  input  logic [MASKW-1:0]             fieldMask,
  output logic [REGAW-1:0]             rfRdAddr,
  input  logic [XLEN-1:0]              rfRdData,
  output logic                         memReqValid,
  output logic [XLEN-1:0]              memReqAddr,
  input  logic                         memRspValid,
  input  logic [2*XLEN-1:0]            memRspData,
  input  logic                         memRspTag,
  output logic                         rfWrEn,
  output logic [REGAW-1:0]             rfWrAddrEven,
  output logic [XLEN-1:0]              rfWrDataHi,
  output logic [XLEN-1:0]              rfWrDataLo,
  output logic                         excWrEn,
  output logic [$clog2(EXC_COUNT)-1:0] excWrIdx,
  output logic                         excWrVal,
  output logic                         alignFault
);

  ldStrobe_t strb;
  logic      issueBad;

  assign rfRdAddr = fieldBase;

  tagLoadCtl uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .issueValid  (issueValid),
    .issueBad    (issueBad),
    .memRspValid (memRspValid),
    .strb        (strb),
    .memReqValid (memReqValid),
    .issueReady  (issueReady)
  );

  tagLoadPath #(
    .XLEN(XLEN), .REGAW(REGAW), .DISPW(DISPW), .MASKW(MASKW),
    .EXC_BASE(EXC_BASE), .EXC_COUNT(EXC_COUNT), .EXC_BIT(EXC_BIT)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .fieldTgt     (fieldTgt),
    .fieldDisp    (fieldDisp),
    .fieldMask    (fieldMask),
    .baseVal      (rfRdData),
    .memRspData   (memRspData),
    .memRspTag    (memRspTag),
    .issueBad     (issueBad),
    .memReqAddr   (memReqAddr),
    .alignFault   (alignFault),
    .rfWrEn       (rfWrEn),
    .rfWrAddrEven (rfWrAddrEven),
    .rfWrDataHi   (rfWrDataHi),
    .rfWrDataLo   (rfWrDataLo),
    .excWrEn      (excWrEn),
    .excWrIdx     (excWrIdx),
    .excWrVal     (excWrVal)
  );

endmodule

// File: tb/sim_tagLoadUnit.sv
`timescale 1ns/1ps
module sim_tagLoadUnit;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         issueValid = 1'b0;
  logic         issueReady;
  logic [4:0]   fieldTgt = '0, fieldBase = '0;
  logic [15:0]  fieldDisp = '0;
  logic [3:0]   fieldMask = '0;
  logic [4:0]   rfRdAddr;
  logic [63:0]  rfRdData;
  logic         memReqValid;
  logic [63:0]  memReqAddr;
  logic         memRspValid = 1'b0;
  logic [127:0] memRspData = '0;
  logic         memRspTag = 1'b0;
  logic         rfWrEn;
  logic [4:0]   rfWrAddrEven;
  logic [63:0]  rfWrDataHi, rfWrDataLo;
  logic         excWrEn;
  logic [3:0]   excWrIdx;
  logic         excWrVal;
  logic         alignFault;

  logic [63:0] rf [32];
  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;   // 50 MHz

  assign rfRdData = rf[rfRdAddr];

  tagLoadUnit u0 (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expHit(input logic [127:0] d, input logic tag, input logic [3:0] mask);
    logic [3:0] ty;
    ty = d[127:124];
    return tag && ($countones(ty) == 1) && ((ty & mask) != 4'd0);
  endfunction

  task automatic runLoad(input logic [4:0] rt, input logic [4:0] base, input logic [15:0] disp,
                         input logic [3:0] mask, input logic [127:0] data, input logic tag,
                         input int lat, input bit poke, input string req);
    logic [63:0] ea;
    bit bad;
    ea  = rf[base] + {{48{disp[15]}}, disp};
    bad = (ea[3:0] != 4'd0) || rt[0];
    @(negedge clk);
    fieldTgt = rt; fieldBase = base; fieldDisp = disp; fieldMask = mask; issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
    if (bad) begin
      chk("R2 fault", alignFault, 1);
      chk("R2 no req", memReqValid, 0);
      @(negedge clk);
      chk("R2 no write", {alignFault, memReqValid, rfWrEn, excWrEn}, 0);
      return;
    end
    chk("R1 req", memReqValid, 1);
    chk("R1 addr", memReqAddr, ea);
    chk("R8 busy", issueReady, 0);
    if (poke) begin
      fieldBase = base + 5'd1; issueValid = 1'b1;
    end
    @(negedge clk);
    issueValid = 1'b0;
    chk("R1 R8 single req", memReqValid, 0);
    repeat (lat) @(negedge clk);
    memRspValid = 1'b1; memRspData = data; memRspTag = tag;
    @(negedge clk);
    memRspValid = 1'b0;
    chk("R3 wr", {rfWrEn, rfWrAddrEven}, {1'b1, rt});
    chk("R3 hi", rfWrDataHi, data[127:64]);
    chk("R3 lo", rfWrDataLo, data[63:0]);
    chk("R4 exc", {excWrEn, excWrIdx}, {1'b1, 4'd9});
    chk(req, excWrVal, expHit(data, tag, mask));
    rf[rt] = data[127:64]; rf[rt + 5'd1] = data[63:0];
    @(negedge clk);
    chk("R8 idle", {issueReady, rfWrEn, excWrEn}, 3'b100);
  endtask

  function automatic logic [15:0] alignDisp(input logic [4:0] base, input logic [15:0] r);
    return {r[15:4], 4'd0} - {12'd0, rf[base][3:0]};
  endfunction

  function automatic logic [127:0] mkData(input logic [3:0] ty);
    return {ty, 60'($urandom) ^ {28'd0, 32'($urandom)}, 32'($urandom), 32'($urandom)};
  endfunction

  initial begin
    #(20 * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 32; i++) rf[i] = {32'($urandom), 32'($urandom)};
    rf[3] = 64'h0000_0000_0001_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset", {issueReady, memReqValid, rfWrEn, excWrEn, alignFault}, 5'b10000);

    // directed corners
    for (int t = 0; t < 4; t++)
      runLoad(5'd4, 5'd3, 16'h0040, 4'b0001 << t, mkData(4'b0001 << t), 1'b1, t, 1'b0, "R5 match");
    runLoad(5'd6, 5'd3, 16'h0020, 4'b0000, mkData(4'b0100), 1'b1, 1, 1'b0, "R6 zero mask");
    runLoad(5'd8, 5'd3, 16'h0030, 4'b1111, mkData(4'b0010), 1'b0, 0, 1'b0, "R7 no tag");
    runLoad(5'd10, 5'd3, 16'h0010, 4'b0110, mkData(4'b0110), 1'b1, 2, 1'b0, "R5 not one-hot");
    runLoad(5'd10, 5'd3, 16'h0010, 4'b1111, mkData(4'b0000), 1'b1, 0, 1'b0, "R5 empty type");
    runLoad(5'd12, 5'd3, 16'h0040, 4'b1000, mkData(4'b0100), 1'b1, 0, 1'b0, "R5 wrong type");
    runLoad(5'd14, 5'd3, 16'hFFF0, 4'b0100, mkData(4'b0100), 1'b1, 1, 1'b0, "R1 negative disp");
    runLoad(5'd16, 5'd3, 16'h0008, 4'b0100, mkData(4'b0100), 1'b1, 0, 1'b0, "R2 misaligned");
    runLoad(5'd17, 5'd3, 16'h0010, 4'b0100, mkData(4'b0100), 1'b1, 0, 1'b0, "R2 odd target");
    runLoad(5'd18, 5'd3, 16'h0050, 4'b0010, mkData(4'b0010), 1'b1, 3, 1'b1, "R8 poke busy");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [4:0]  rt, base;
      logic [15:0] disp;
      logic [3:0]  ty;
      rt   = 5'($urandom);
      base = 5'($urandom);
      disp = 16'($urandom);
      if ($urandom_range(9) < 8) begin
        rt[0] = 1'b0;
        disp = alignDisp(base, disp);
      end
      ty = ($urandom_range(9) < 7) ? (4'b0001 << $urandom_range(3)) : 4'($urandom);
      runLoad(rt, base, disp, 4'($urandom), mkData(ty), 1'($urandom), $urandom_range(3),
              1'($urandom), "R4 R5 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule